// File: doc/BRIEF.md
# Stream Handshake Firing Wrapper

This block sits between a processing core and two streams: an upstream input stream and a downstream output stream. Each stream carries a valid/ready pair with data. The wrapper also drives the core's per-cycle enable. A four-bit parameter mask declares which handshake terminals the core itself provides. The wrapper decides from that mask how often the core runs.

When the core provides all four terminals, the wrapper is transparent. Every stream signal passes straight between the port and the core in the same cycle, and the core is enabled on every clock, including idle cycles.

With any terminal missing, the wrapper switches to a gated rule:
- The core fires only in a cycle where the upstream transfer completes and no result is waiting to leave.
- Each firing is taken to produce one result, which appears on the core's output register one cycle later.
- A one-entry pending slot holds that result until the downstream side accepts it. Upstream ready stays low while the slot is occupied.
- Missing valid terminals are derived from the enable, and missing ready terminals are derived from the slot state.

Top module: `stream_fire_wrap`

## Requirements
- R1: With the terminal mask `4'b1111`, `core_en` is high in every cycle after reset, whether or not any stream transfer happens.
- R2: With the full mask, `up_ready` equals `core_in_ready`, `dn_valid` equals `core_out_valid`, `dn_data` equals `core_out_data`, `core_out_ready` equals `dn_ready` and `core_in_valid` equals `up_valid`, all in the same cycle.
- R3: In gated mode, `core_en` is high in exactly those cycles where `up_valid` and `up_ready` are both high.
- R4: In gated mode, when the core has no input-ready terminal (mask bit 1 clear), `up_ready` is low while a result is pending and high otherwise.
- R5: In gated mode, when the core has no output-valid terminal (mask bit 2 clear), `dn_valid` rises in the cycle after a firing, and `dn_data` carries the core's output from that cycle.
- R6: While `dn_valid` is high and `dn_ready` is low, `dn_valid` and `dn_data` hold their values. The pending result is released in the cycle after `dn_valid` and `dn_ready` are seen together.
- R7: In gated mode, when the core has no input-valid terminal (mask bit 0 clear), `core_in_valid` equals `core_en`.
- R8: In gated mode, `core_out_ready` is high when no result is pending or when `dn_ready` is high, and low otherwise.
- R9: Synchronous active-low reset clears the pending result. In the cycle after a reset edge, `dn_valid` is low, and in gated mode with no input-ready terminal, `up_ready` is high. This holds even if a result was waiting when reset arrived.
- R10: Results leave downstream in the order their inputs were accepted, each exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| up_valid | input | 1 | Upstream data is offered |
| up_data | input | DW | Upstream data word |
| up_ready | output | 1 | Wrapper can take upstream data |
| dn_valid | output | 1 | A result is offered downstream |
| dn_data | output | DW | Result word |
| dn_ready | input | 1 | Downstream takes the result |
| core_en | output | 1 | Per-cycle enable to the core |
| core_in_valid | output | 1 | Input valid presented to the core |
| core_in_data | output | DW | Input word presented to the core |
| core_in_ready | input | 1 | Core input-ready terminal (ignored when mask bit 1 is clear) |
| core_out_valid | input | 1 | Core output-valid terminal (ignored when mask bit 2 is clear) |
| core_out_data | input | DW | Core result word |
| core_out_ready | output | 1 | Output-ready presented to the core |

## Verification
Two cases are hard to reach from the ports. The first is a long downstream stall while upstream keeps offering data. The second is a reset that lands while a result still sits in the pending slot. The stimulus reaches both on purpose. It holds `dn_ready` low for dozens of cycles with `up_valid` high, so the result must stay frozen and `up_ready` must stay low. It then pulses reset three cycles into a stall, after a firing has filled the slot, and checks that nothing stale leaks out afterwards. Random valid/ready phases around these cover firing and release in the same cycle and back-to-back transfers. A full-mask instance runs alongside the gated one and is fed the same patterns.

// File: rtl/stream_fire_pkg.sv
// Shared definitions for the stream firing wrapper.
// Assumes: terminal masks are four bits, one per handshake terminal the
// wrapped core provides.
package stream_fire_pkg;
    localparam int T_IN_VALID  = 0;
    localparam int T_IN_READY  = 1;
    localparam int T_OUT_VALID = 2;
    localparam int T_OUT_READY = 3;
    localparam logic [3:0] T_ALL = 4'b1111;

    // True when the core handles every handshake terminal itself
    function automatic bit terms_complete(input logic [3:0] m);
        return (m == T_ALL);
    endfunction
endpackage

// File: rtl/stream_fire_gate.sv
// Firing rule: computes upstream ready, the core enable and the core's
// input valid from the terminal mask.
// Assumes: pend is the pending-slot flag; it is 0 when the mask is full.
module stream_fire_gate
    import stream_fire_pkg::*;
#(
    parameter logic [3:0] TERMS = 4'b0000
) (
    input  logic up_valid,
    input  logic core_in_ready,
    input  logic pend,
    output logic up_ready,
    output logic core_en,
    output logic core_in_valid
);
    localparam bit FREE_RUN = terms_complete(TERMS);
    localparam bit USE_IN_READY = TERMS[T_IN_READY];
    localparam bit USE_IN_VALID = TERMS[T_IN_VALID];

    generate
        if (FREE_RUN) begin : g_free
            wire unused_pend = pend;
            // Pass-through: core owns the handshake and runs every cycle
            always_comb begin
                up_ready      = core_in_ready;
                core_en       = 1'b1;
                core_in_valid = up_valid;
            end
        end else begin : g_gated
            logic in_room;
            // Fire only on a completed read with an empty pending slot
            always_comb begin
                in_room       = USE_IN_READY ? core_in_ready : 1'b1;
                up_ready      = !pend && in_room;
                core_en       = up_valid && up_ready;
                core_in_valid = USE_IN_VALID ? up_valid : core_en;
            end
        end
    endgenerate
endmodule

// File: rtl/stream_pend_slot.sv
// One-entry pending-output slot for the gated firing rule.
// Assumes: a firing yields one result on the core's output register one
// cycle later; fire never coincides with an occupied slot.
module stream_pend_slot #(
    parameter int DW            = 16,
    parameter bit USE_OUT_VALID = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fire,
    input  logic          core_out_valid,
    input  logic [DW-1:0] core_out_data,
    input  logic          dn_ready,
    output logic          pend,
    output logic          dn_valid,
    output logic [DW-1:0] dn_data,
    output logic          core_out_ready
);
    logic          pend_q;
    logic          cap_q;
    logic [DW-1:0] data_q;
    logic          res_ok;
    logic          take;
    logic          bypass;

    // Combine slot state with the core's own valid when present
    always_comb begin
        res_ok         = USE_OUT_VALID ? core_out_valid : 1'b1;
        dn_valid       = pend_q && res_ok;
        take           = dn_valid && dn_ready;
        bypass         = pend_q && !cap_q;
        dn_data        = bypass ? core_out_data : data_q;
        core_out_ready = !pend_q || dn_ready;
        pend           = pend_q;
    end

    // Slot occupancy: set by a firing, cleared by a downstream transfer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (fire) begin
            pend_q <= 1'b1;
        end else if (take) begin
            pend_q <= 1'b0;
        end
    end

    // Capture the result once it is valid so it stays frozen while held
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q <= 1'b0;
        end else if (fire) begin
            cap_q <= 1'b0;
        end else if (bypass && res_ok) begin
            cap_q <= 1'b1;
        end
    end

    // Result storage register
    always_ff @(posedge clk) begin
        if (bypass && res_ok) begin
            data_q <= core_out_data;
        end
    end
endmodule

// File: rtl/stream_fire_wrap.sv
// Stream handshake firing wrapper (top).
// Selects, from the TERMS mask, either a free-running pass-through or a
// gated rule with a one-entry pending slot. Mask bits: 0 core input valid,
// 1 core input ready, 2 core output valid, 3 core output ready.
// Assumes: in gated mode the core updates its output register only when
// enabled, one enabled cycle per result.
module stream_fire_wrap
    import stream_fire_pkg::*;
#(
    parameter int         DW    = 16,
    parameter logic [3:0] TERMS = 4'b0000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          up_valid,
    input  logic [DW-1:0] up_data,
    output logic          up_ready,
    output logic          dn_valid,
    output logic [DW-1:0] dn_data,
    input  logic          dn_ready,
    output logic          core_en,
    output logic          core_in_valid,
    output logic [DW-1:0] core_in_data,
    input  logic          core_in_ready,
    input  logic          core_out_valid,
    input  logic [DW-1:0] core_out_data,
    output logic          core_out_ready
);
    localparam bit FREE_RUN = terms_complete(TERMS);

    logic pend;

    assign core_in_data = up_data;

    stream_fire_gate #(
        .TERMS(TERMS)
    ) u_gate (
        .up_valid     (up_valid),
        .core_in_ready(core_in_ready),
        .pend         (pend),
        .up_ready     (up_ready),
        .core_en      (core_en),
        .core_in_valid(core_in_valid)
    );

    generate
        if (FREE_RUN) begin : g_free
            wire unused_clk = clk ^ rst_n;
            // Output side passes straight through
            always_comb begin
                pend           = 1'b0;
                dn_valid       = core_out_valid;
                dn_data        = core_out_data;
                core_out_ready = dn_ready;
            end
        end else begin : g_gated
            stream_pend_slot #(
                .DW           (DW),
                .USE_OUT_VALID(TERMS[T_OUT_VALID])
            ) u_slot (
                .clk           (clk),
                .rst_n         (rst_n),
                .fire          (core_en),
                .core_out_valid(core_out_valid),
                .core_out_data (core_out_data),
                .dn_ready      (dn_ready),
                .pend          (pend),
                .dn_valid      (dn_valid),
                .dn_data       (dn_data),
                .core_out_ready(core_out_ready)
            );
        end
    endgenerate
endmodule

// File: rtl/stream_fire_chk.sv
// Protocol checker for stream_fire_wrap, attached by bind below.
// Assumes: synchronous active-low reset on clk.
module stream_fire_chk
    import stream_fire_pkg::*;
#(
    parameter int         DW    = 16,
    parameter logic [3:0] TERMS = 4'b0000
) (
    input logic          clk,
    input logic          rst_n,
    input logic          up_valid,
    input logic          up_ready,
    input logic          dn_valid,
    input logic [DW-1:0] dn_data,
    input logic          dn_ready,
    input logic          core_en,
    input logic          core_out_ready
);
    // Downstream hold while stalled
    assert_out_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_valid && !dn_ready) |=> (dn_valid && $stable(dn_data)));

    generate
        if (!terms_complete(TERMS)) begin : g_gated
            assert_fire_on_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
                core_en |-> (up_valid && up_ready));
            assert_block_pending_R4: assert property (@(posedge clk) disable iff (!rst_n)
                dn_valid |-> !up_ready);
            assert_stall_core_R8: assert property (@(posedge clk) disable iff (!rst_n)
                (dn_valid && !dn_ready) |-> !core_out_ready);
            assert_reset_clear_R9: assert property (@(posedge clk)
                !rst_n |=> !dn_valid);
            if (!TERMS[T_OUT_VALID]) begin : g_ov
                assert_result_next_R5: assert property (@(posedge clk) disable iff (!rst_n)
                    core_en |=> dn_valid);
            end
        end
    endgenerate
endmodule

bind stream_fire_wrap stream_fire_chk #(
    .DW   (DW),
    .TERMS(TERMS)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .up_valid      (up_valid),
    .up_ready      (up_ready),
    .dn_valid      (dn_valid),
    .dn_data       (dn_data),
    .dn_ready      (dn_ready),
    .core_en       (core_en),
    .core_out_ready(core_out_ready)
);

// File: tb/sim_stream_fire_wrap.sv
`timescale 1ns/1ps

// Bench core without handshake: output register loads 3*x+1 when enabled
module sim_core_reg #(parameter int DW = 16) (
    input  logic          clk,
    input  logic          en,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout
);
    always_ff @(posedge clk) begin
        if (en) dout <= din * 3 + 1;
    end
endmodule

// Bench core with all four terminals: one-entry buffer holding 3*x+1
module sim_core_buf #(parameter int DW = 16) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          in_valid,
    input  logic [DW-1:0] din,
    output logic          in_ready,
    output logic          out_valid,
    output logic [DW-1:0] dout,
    input  logic          out_ready
);
    assign in_ready = !out_valid || out_ready;
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else if (en) begin
            if (in_valid && in_ready) begin
                out_valid <= 1'b1;
                dout      <= din * 3 + 1;
            end else if (out_ready) out_valid <= 1'b0;
        end
    end
endmodule

module sim_stream_fire_wrap;
    localparam int DW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic up_valid = 1'b0;
    logic [DW-1:0] up_data = '0;
    logic dn_ready = 1'b0;

    always #2.5 clk = ~clk;

    // Gated instance (no terminals)
    logic up_ready0, dn_valid0, core_en0, civ0, cor0;
    logic [DW-1:0] dn_data0, cid0, cod0;
    // Free-running instance (all terminals)
    logic up_ready1, dn_valid1, core_en1, civ1, cor1, cir1, cov1;
    logic [DW-1:0] dn_data1, cid1, cod1;

    stream_fire_wrap #(.DW(DW), .TERMS(4'b0000)) u0 (
        .clk(clk), .rst_n(rst_n), .up_valid(up_valid), .up_data(up_data),
        .up_ready(up_ready0), .dn_valid(dn_valid0), .dn_data(dn_data0),
        .dn_ready(dn_ready), .core_en(core_en0), .core_in_valid(civ0),
        .core_in_data(cid0), .core_in_ready(1'b0), .core_out_valid(1'b0),
        .core_out_data(cod0), .core_out_ready(cor0));
    sim_core_reg #(.DW(DW)) u_core0 (.clk(clk), .en(core_en0), .din(cid0), .dout(cod0));

    stream_fire_wrap #(.DW(DW), .TERMS(4'b1111)) u1 (
        .clk(clk), .rst_n(rst_n), .up_valid(up_valid), .up_data(up_data),
        .up_ready(up_ready1), .dn_valid(dn_valid1), .dn_data(dn_data1),
        .dn_ready(dn_ready), .core_en(core_en1), .core_in_valid(civ1),
        .core_in_data(cid1), .core_in_ready(cir1), .core_out_valid(cov1),
        .core_out_data(cod1), .core_out_ready(cor1));
    sim_core_buf #(.DW(DW)) u_core1 (.clk(clk), .rst_n(rst_n), .en(core_en1),
        .in_valid(civ1), .din(cid1), .in_ready(cir1), .out_valid(cov1),
        .dout(cod1), .out_ready(cor1));

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 0;

    // Reference model state
    bit pm0 = 0;
    bit fm1 = 0;
    logic [DW-1:0] q0[$];
    logic [DW-1:0] q1[$];
    bit hold0 = 0;
    logic [DW-1:0] last0 = '0;

    function automatic logic [DW-1:0] xf(input logic [DW-1:0] x);
        return x * 3 + 1;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Compare both instances with the model, then advance the model
    task automatic compare_cycle();
        bit er0, acc0, tk0, er1, acc1, tk1;
        er0 = !pm0;
        acc0 = up_valid && er0;
        check(up_ready0 == er0, "R4 up_ready", up_ready0, er0);
        check(core_en0 == acc0, "R3 core_en", core_en0, acc0);
        check(civ0 == acc0, "R7 core_in_valid", civ0, acc0);
        check(dn_valid0 == pm0, "R5 dn_valid", dn_valid0, pm0);
        check(cor0 == (!pm0 || dn_ready), "R8 core_out_ready", cor0, (!pm0 || dn_ready));
        if (pm0) check(dn_data0 == q0[0], "R10 gated order", dn_data0, q0[0]);
        if (hold0) check(dn_data0 == last0 && dn_valid0, "R6 hold", dn_data0, last0);
        tk0 = pm0 && dn_ready;
        hold0 = pm0 && !dn_ready;
        last0 = dn_data0;
        if (tk0) void'(q0.pop_front());
        if (acc0) q0.push_back(xf(up_data));
        pm0 = acc0 || (pm0 && !tk0);

        er1 = !fm1 || dn_ready;
        acc1 = up_valid && er1;
        check(core_en1 == 1'b1, "R1 core_en", core_en1, 1);
        check(up_ready1 == cir1 && up_ready1 == er1, "R2 up_ready", up_ready1, er1);
        check(dn_valid1 == cov1 && dn_valid1 == fm1, "R2 dn_valid", dn_valid1, fm1);
        check(dn_data1 == cod1 && cor1 == dn_ready && civ1 == up_valid, "R2 pass",
              dn_data1, cod1);
        if (fm1) check(dn_data1 == q1[0], "R10 free order", dn_data1, q1[0]);
        tk1 = fm1 && dn_ready;
        if (tk1) void'(q1.pop_front());
        if (acc1) q1.push_back(xf(up_data));
        fm1 = acc1 || (fm1 && !tk1);
    endtask

    task automatic step(input bit v, input bit r);
        @(negedge clk);
        up_valid = v;
        dn_ready = r;
        up_data = DW'($urandom);
        #1;
        compare_cycle();
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
            summary();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(dn_valid0 == 1'b0, "R9 reset dn_valid", dn_valid0, 0);
        check(dn_valid1 == 1'b0, "R9 reset dn_valid free", dn_valid1, 0);
        rst_n = 1'b1;
        #1;
        check(up_ready0 == 1'b1, "R9 reset up_ready", up_ready0, 1);

        // Streaming with both sides always willing
        for (int i = 0; i < 40; i++) step(1'b1, 1'b1);
        // Random valid and ready
        for (int i = 0; i < 300; i++) step(1'($urandom), 1'($urandom));
        // Long downstream stall with upstream offering
        for (int i = 0; i < 30; i++) step(1'b1, 1'b0);
        for (int i = 0; i < 20; i++) step(1'b1, 1'b1);
        // Idle upstream: free instance still enabled
        for (int i = 0; i < 20; i++) step(1'b0, 1'($urandom));

        // Reset while a result is pending
        for (int i = 0; i < 3; i++) step(1'b1, 1'b0);
        check(dn_valid0 == 1'b1, "R9 pending before reset", dn_valid0, 1);
        @(negedge clk);
        rst_n = 1'b0;
        up_valid = 1'b0;
        @(negedge clk);
        check(dn_valid0 == 1'b0, "R9 reset clears pending", dn_valid0, 0);
        check(dn_valid1 == 1'b0, "R9 reset clears free", dn_valid1, 0);
        rst_n = 1'b1;
        pm0 = 0; fm1 = 0; hold0 = 0;
        q0.delete(); q1.delete();
        #1;
        check(up_ready0 == 1'b1, "R9 up_ready after reset", up_ready0, 1);
        for (int i = 0; i < 200; i++) step(1'($urandom), 1'($urandom));
        for (int i = 0; i < 5; i++) step(1'b0, 1'b1);

        done = 1;
        summary();
    end
endmodule